// File: doc/BRIEF.md
# Multi-Channel Delay-Line Phase Generator

The block turns one fast system clock into several square-wave reference clocks, all of the same frequency, whose phases are set one channel at a time. A free-running counter divides the system clock by 256 and gives a common reference with a 50% duty cycle. Each channel feeds that reference into its own clocked shift-register delay line. A tap chosen by the channel's 8-bit phase word selects the output. One stage of delay equals one system clock cycle, or 1/256 of the output period, so the 256 word values cover a full turn of phase. With a 256 MHz system clock the outputs run at 1 MHz in steps of about 1.406°.

A host writes phase words through a single-cycle strobe that carries a channel index and a value. A write lands in a per-channel shadow register. The shadow is copied to the tap that is in use only when the reference counter wraps, so a tap never changes part way through a period. No sine table, accumulator or converter is involved; the output phase depends only on how many stages the reference passes through.

Top module: `phase_shift_clkgen`

## Requirements
- R1: After synchronous reset (rst_i high) the reference counter is 0, every shadow and active phase word is 0 and every delay stage is 0. In the first cycle after release every channel output equals the reference, which is high.
- R2: The reference has a period of 256 system clock cycles. Counting n cycles since reset release, it is high when n mod 256 is in 0..127 and low when it is in 128..255.
- R3: With active phase word k, a channel output equals the reference delayed by exactly k system clock cycles. k = 0 passes the reference through with no delay.
- R4: While fewer than k cycles have passed since reset release, a channel with active word k drives 0, because its delay stages have not yet filled.
- R5: A write (wr_en_i high for one cycle) stores wr_phase_i in the shadow word of the channel whose number is wr_ch_i, 0 to 3. No other channel's shadow changes.
- R6: Shadow words are copied to the active words only on the clock edge where the counter steps from 255 to 0. A write made in the cycle where the count is 255 is copied at the next wrap, one period later. A write made at any earlier point in the period takes effect at the coming wrap.
- R7: Changing one channel's phase word leaves every other channel's output unchanged, cycle for cycle.
- R8: When several writes to the same channel land within one period, the last one before the wrap edge is the one copied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one cycle is one delay step |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Phase-word write strobe, one cycle per write |
| wr_ch_i | input | 2 | Channel number addressed by the write |
| wr_phase_i | input | 8 | Phase word; delay in system clock cycles |
| phase_clk_o | output | 4 | Square-wave output, one bit per channel |

## Verification
The assertions assume that reset is held high from time zero until the first edges have passed and that write strobes, channel numbers and phase values are defined whenever reset is low. The shadow-capture check also assumes that a strobe names a valid channel index. The bench changes inputs only on falling edges and drives every write field to a known value on every cycle, with the strobe low between writes. Its stimulus includes single writes, back-to-back writes to one channel and a write placed in the cycle where the count is 255. All of these stay inside those assumptions.

// File: rtl/phase_gen_pkg.sv
package phase_gen_pkg;
    localparam int DEF_CHANNELS = 4;
    localparam int DEF_PHASE_W  = 8;

    function automatic int chan_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pg_ref_gen.sv
module pg_ref_gen #(
    parameter int PHASE_W = phase_gen_pkg::DEF_PHASE_W
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic ref_o,
    output logic wrap_o
);
    localparam logic [PHASE_W-1:0] ONE     = PHASE_W'(1);
    localparam logic [PHASE_W-1:0] CNT_TOP = {PHASE_W{1'b1}};

    typedef struct packed {
        logic [PHASE_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + ONE;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign ref_o  = ~st_q.cnt[PHASE_W-1];
    assign wrap_o = (st_q.cnt == CNT_TOP);

    // R2
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> st_q.cnt == $past(st_q.cnt) + ONE);

    // R2
    ref_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(ref_o) |-> st_q.cnt == '0);
endmodule

// File: rtl/pg_phase_bank.sv
module pg_phase_bank #(
    parameter int NCH     = phase_gen_pkg::DEF_CHANNELS,
    parameter int PHASE_W = phase_gen_pkg::DEF_PHASE_W,
    parameter int CH_W    = phase_gen_pkg::chan_idx_w(NCH)
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   wr_en_i,
    input  logic [CH_W-1:0]        wr_ch_i,
    input  logic [PHASE_W-1:0]     wr_phase_i,
    input  logic                   wrap_i,
    output logic [NCH*PHASE_W-1:0] taps_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] shadow;
        logic [PHASE_W-1:0] active;
    } slot_t;

    slot_t [NCH-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            if (wrap_i)
                st_d[c].active = st_q[c].shadow;
            if (wr_en_i && (wr_ch_i == CH_W'(c)))
                st_d[c].shadow = wr_phase_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        localparam logic [CH_W-1:0] IDX = CH_W'(g);

        assign taps_o[g*PHASE_W +: PHASE_W] = st_q[g].active;

        // R5
        shadow_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (wr_en_i && wr_ch_i == IDX) |=> st_q[g].shadow == $past(wr_phase_i));

        // R5
        shadow_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !(wr_en_i && wr_ch_i == IDX) |=> $stable(st_q[g].shadow));

        // R6
        active_wrap_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !wrap_i |=> $stable(st_q[g].active));
    end
endmodule

// File: rtl/pg_delay_line.sv
module pg_delay_line #(
    parameter int PHASE_W = phase_gen_pkg::DEF_PHASE_W
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               ref_i,
    input  logic [PHASE_W-1:0] tap_i,
    output logic               out_o
);
    localparam int DEPTH = (1 << PHASE_W) - 1;
    localparam logic [PHASE_W-1:0] ONE = PHASE_W'(1);

    typedef struct packed {
        logic [DEPTH-1:0] stage;
    } state_t;

    state_t st_d, st_q;
    logic [PHASE_W-1:0] sel;

    always_comb begin
        st_d       = st_q;
        st_d.stage = {st_q.stage[DEPTH-2:0], ref_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    always_comb begin
        sel   = tap_i - ONE;
        out_o = (tap_i == '0) ? ref_i : st_q.stage[sel];
    end

    // R3
    first_stage_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> st_q.stage[0] == $past(ref_i));
endmodule

// File: rtl/phase_shift_clkgen.sv
module phase_shift_clkgen #(
    parameter int NCH     = phase_gen_pkg::DEF_CHANNELS,
    parameter int PHASE_W = phase_gen_pkg::DEF_PHASE_W,
    parameter int CH_W    = phase_gen_pkg::chan_idx_w(NCH)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_en_i,
    input  logic [CH_W-1:0]    wr_ch_i,
    input  logic [PHASE_W-1:0] wr_phase_i,
    output logic [NCH-1:0]     phase_clk_o
);
    logic                   ref_sq;
    logic                   wrap;
    logic [NCH*PHASE_W-1:0] taps;

    pg_ref_gen #(.PHASE_W(PHASE_W)) i_ref (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ref_o  (ref_sq),
        .wrap_o (wrap)
    );

    pg_phase_bank #(.NCH(NCH), .PHASE_W(PHASE_W), .CH_W(CH_W)) i_bank (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .wr_ch_i    (wr_ch_i),
        .wr_phase_i (wr_phase_i),
        .wrap_i     (wrap),
        .taps_o     (taps)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pg_delay_line #(.PHASE_W(PHASE_W)) i_line (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .ref_i (ref_sq),
            .tap_i (taps[g*PHASE_W +: PHASE_W]),
            .out_o (phase_clk_o[g])
        );
    end

    // R1
    post_reset_chk: assert property (@(posedge clk_i)
        $fell(rst_i) |-> phase_clk_o == {NCH{1'b1}});
endmodule

// File: tb/test_phase_shift_clkgen.sv
module test_phase_shift_clkgen;
    localparam int NCH = 4;
    localparam int PW  = 8;
    localparam int PER = 256;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_ch = '0;
    logic [PW-1:0]  wr_phase = '0;
    logic [NCH-1:0] phase_clk;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int shadow_m [NCH];
    int active_m [NCH];
    string tag = "R1";

    always #4 clk = ~clk;

    phase_shift_clkgen i_phase_shift_clkgen (
        .clk_i       (clk),
        .rst_i       (rst),
        .wr_en_i     (wr_en),
        .wr_ch_i     (wr_ch),
        .wr_phase_i  (wr_phase),
        .phase_clk_o (phase_clk)
    );

    function automatic logic expect_bit(int cyc, int k);
        if (cyc < k) return 1'b0;               // R4
        return (((cyc - k) % PER) < PER / 2);   // R2, R3
    endfunction

    task automatic check_all();
        for (int c = 0; c < NCH; c++) begin
            logic e;
            string t;
            e = expect_bit(n, active_m[c]);
            t = (n < active_m[c]) ? "R4" : tag;
            checks++;
            if (phase_clk[c] !== e) begin
                errors++;
                $display("FAIL %s ch%0d cyc=%0d k=%0d got %b exp %b",
                         t, c, n, active_m[c], phase_clk[c], e);
            end
        end
    endtask

    task automatic tick(input logic we, input int ch, input int v);
        check_all();
        wr_en    = we;
        wr_ch    = 2'(ch);
        wr_phase = PW'(v);
        @(posedge clk);
        if ((n % PER) == PER - 1)
            for (int c = 0; c < NCH; c++) active_m[c] = shadow_m[c];   // R6
        if (we) shadow_m[ch] = v;                                       // R5
        n++;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) tick(1'b0, 0, 0);
    endtask

    task automatic run_to_count(input int target);
        while ((n % PER) != target) tick(1'b0, 0, 0);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            shadow_m[c] = 0;
            active_m[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: first cycle after release, all outputs follow the high reference
        tag = "R1";
        check_all();
        tag = "R2";
        idle(300);

        // R3, R4: sweep every phase word on every channel
        tag = "R3";
        for (int p = 0; p < PER; p++) begin
            run_to_count(10);
            for (int c = 0; c < NCH; c++)
                tick(1'b1, c, (p * (2 * c + 1) + 64 * c) % PER);
            run_to_count(0);
            idle(PER - 4);
        end

        // R6: write in the count-255 cycle waits a full period
        tag = "R6";
        run_to_count(PER - 1);
        tick(1'b1, 1, 37);
        idle(PER + 20);

        // R8: back-to-back writes, last one wins
        tag = "R8";
        run_to_count(100);
        tick(1'b1, 3, 5);
        tick(1'b1, 3, 200);
        tick(1'b1, 3, 77);
        idle(PER + 20);

        // R7: change only channel 2, others continue unchanged
        tag = "R7";
        run_to_count(50);
        tick(1'b1, 2, 129);
        idle(2 * PER);

        // R5: each channel addressed alone, extremes
        tag = "R5";
        run_to_count(30);
        tick(1'b1, 0, 255);
        tick(1'b1, 1, 0);
        tick(1'b1, 2, 1);
        tick(1'b1, 3, 128);
        idle(2 * PER);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", n);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule